// File: doc/BRIEF.md
# Three-Modulus Final Carry-Propagate Adder

This block is the last stage of a residue multiplier. It takes the two rows that a carry-save tree leaves behind and resolves them into one residue. A two-bit mode input picks the modulus: 2^N, 2^N−1 or 2^N+1. A single parallel-prefix carry network is built once and shared by all three moduli. The mode only changes the carry that is injected at bit 0. That carry is zero for 2^N, the carry-out itself for 2^N−1, and the inverted carry-out for 2^N+1.

In the 2^N+1 mode the adder works in the diminished-one style. The rows are added together with one extra unit of correction. The result can take the value 2^N, so the output has one bit more than the operands; that top bit is set only for this value. In the 2^N−1 mode an all-ones word counts as a second code for zero, on input and internally. The output always shows zero as all-zeros.

A parameter selects the prefix topology: Sklansky, Kogge-Stone or Brent-Kung. All three give identical results. The sum is registered once, so a result appears on the output one clock after its operands and mode are presented.

Top module: `mm_tri_adder`

## Requirements
- R1: While rst_n is low, res_o is all-zeros. It stays all-zeros until the first clock edge after release that captures operands.
- R2: With mode_i = 2'b00, res_o equals (a_i + b_i) mod 2^N one clock after the inputs. Bit N of res_o is 0.
- R3: With mode_i = 2'b01, res_o equals (a_i + b_i) mod (2^N − 1) one clock after the inputs. An all-ones operand behaves as zero, and bit N of res_o is 0.
- R4: With mode_i = 2'b01, res_o[N-1:0] is never all-ones. A sum that is congruent to zero is always shown as all-zeros.
- R5: With mode_i = 2'b10, res_o equals (a_i + b_i + 1) mod (2^N + 1) one clock after the inputs, on N+1 bits. Bit N is 1 only for the value 2^N, and then bits N-1..0 are all zero.
- R6: With mode_i = 2'b11, the block behaves exactly as with mode_i = 2'b00.
- R7: Instances that differ only in the topology parameter (0 Sklansky, 1 Kogge-Stone, 2 Brent-Kung) produce identical res_o for identical inputs.
- R8: R2 to R5 hold for operand widths N = 8, 16 and 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| mode_i | input | 2 | Modulus select: 00 = 2^N, 01 = 2^N−1, 10 = 2^N+1, 11 = same as 00 |
| a_i | input | N | First operand row |
| b_i | input | N | Second operand row |
| res_o | output | N+1 | Registered residue; bit N is used only by the 2^N+1 mode |

## Verification
The bench aims at the operand pairs where the injected carry decides the answer. One such pair is two complementary operands whose sum is exactly all-ones; a 2^N−1 adder that skips normalisation would return all-ones there, and a 2^N+1 adder that lost the top bit would return zero instead of 2^N. The other pairs are two all-ones operands, an all-ones operand with zero, and an all-ones operand with one. These expose a wrong polarity of the carry fed back in each mode, as an off-by-one residue or a missing wrap. Every pair is applied in every mode, including the spare code, and is followed by random operands. The bench compares five instances, covering three topologies and widths of 8, 16 and 32 bits, so a miswired prefix node in any one topology shows up as a disagreement on some carry position.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [1:0] {
        MODE_POW2   = 2'b00,
        MODE_MINUS1 = 2'b01,
        MODE_PLUS1  = 2'b10,
        MODE_SPARE  = 2'b11
    } mod_mode_e;

    typedef enum logic [1:0] {
        TOPO_SKLANSKY = 2'd0,
        TOPO_KOGGE    = 2'd1,
        TOPO_BRENT    = 2'd2
    } topo_e;

endpackage

// File: rtl/mm_prefix_tree.sv
module mm_prefix_tree #(
    parameter int            N    = 16,
    parameter mm_pkg::topo_e TOPO = mm_pkg::TOPO_SKLANSKY
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    output logic [N-1:0] gp_o,
    output logic [N-1:0] pp_o
);
    import mm_pkg::*;

    localparam int LV     = $clog2(N);
    localparam int STAGES = (TOPO == TOPO_BRENT) ? (2 * LV - 1) : LV;

    // Index of the node merged into bit i at stage s, or -1 to pass through.
    function automatic int partner(input int s, input int i);
        int l;
        int j;
        j = -1;
        case (TOPO)
            TOPO_KOGGE: begin
                if (i >= (1 << s)) j = i - (1 << s);
            end
            TOPO_BRENT: begin
                if (s < LV) begin
                    l = s;
                    if (((i + 1) % (2 << l)) == 0) j = i - (1 << l);
                end else begin
                    l = 2 * LV - 2 - s;
                    if ((((i + 1) % (2 << l)) == (1 << l)) &&
                        (i >= ((2 << l) + (1 << l) - 1)))
                        j = i - (1 << l);
                end
            end
            default: begin
                if (((i >> s) & 1) == 1) j = ((i >> s) << s) - 1;
            end
        endcase
        return j;
    endfunction

    logic [N-1:0] gs [0:STAGES];
    logic [N-1:0] ps [0:STAGES];

    always_comb begin
        gs[0] = g_i;
        ps[0] = p_i;
        for (int s = 0; s < STAGES; s++) begin
            for (int i = 0; i < N; i++) begin
                int j;
                j = partner(s, i);
                if (j >= 0) begin
                    gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][j]);
                    ps[s+1][i] = ps[s][i] & ps[s][j];
                end else begin
                    gs[s+1][i] = gs[s][i];
                    ps[s+1][i] = ps[s][i];
                end
            end
        end
    end

    assign gp_o = gs[STAGES];
    assign pp_o = ps[STAGES];

endmodule

// File: rtl/mm_eac_select.sv
module mm_eac_select (
    input  mm_pkg::mod_mode_e mode_i,
    input  logic              g_all_i,
    input  logic              p_all_i,
    output logic              cin_o,
    output logic              top_o
);
    import mm_pkg::*;

    always_comb begin
        case (mode_i)
            MODE_MINUS1: cin_o = g_all_i;
            MODE_PLUS1:  cin_o = ~g_all_i;
            default:     cin_o = 1'b0;
        endcase
        // Value 2^N: no carry out of the plain sum, and every bit propagates
        // the injected unit.
        top_o = (mode_i == MODE_PLUS1) & p_all_i & ~g_all_i;
    end

endmodule

// File: rtl/mm_sum_stage.sv
module mm_sum_stage #(
    parameter int N = 16
) (
    input  logic [N-1:0] p_i,
    input  logic [N-2:0] gp_i,
    input  logic [N-2:0] pp_i,
    input  logic         cin_i,
    input  logic         norm_i,
    output logic [N-1:0] low_o
);
    logic [N-1:0] carry;
    logic [N-1:0] raw;

    always_comb begin
        carry[0] = cin_i;
        for (int i = 1; i < N; i++) begin
            carry[i] = gp_i[i-1] | (pp_i[i-1] & cin_i);
        end
        raw = p_i ^ carry;
        if (norm_i && (&raw)) begin
            low_o = '0;
        end else begin
            low_o = raw;
        end
    end

endmodule

// File: rtl/mm_tri_adder.sv
module mm_tri_adder #(
    parameter int            N    = 16,
    parameter mm_pkg::topo_e TOPO = mm_pkg::TOPO_SKLANSKY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N:0]   res_o
);
    import mm_pkg::*;

    typedef struct packed {
        logic         top;
        logic [N-1:0] low;
    } res_t;

    mod_mode_e    mode;
    logic [N-1:0] g_bit;
    logic [N-1:0] p_bit;
    logic [N-1:0] g_pre;
    logic [N-1:0] p_pre;
    logic         cin;
    logic         top;
    logic [N-1:0] low;
    res_t         res_d;
    res_t         res_q;

    assign mode  = mod_mode_e'(mode_i);
    assign g_bit = a_i & b_i;
    assign p_bit = a_i ^ b_i;

    mm_prefix_tree #(
        .N    (N),
        .TOPO (TOPO)
    ) tree_i (
        .g_i  (g_bit),
        .p_i  (p_bit),
        .gp_o (g_pre),
        .pp_o (p_pre)
    );

    mm_eac_select eac_i (
        .mode_i  (mode),
        .g_all_i (g_pre[N-1]),
        .p_all_i (p_pre[N-1]),
        .cin_o   (cin),
        .top_o   (top)
    );

    mm_sum_stage #(
        .N (N)
    ) sum_i (
        .p_i    (p_bit),
        .gp_i   (g_pre[N-2:0]),
        .pp_i   (p_pre[N-2:0]),
        .cin_i  (cin),
        .norm_i (mode == MODE_MINUS1),
        .low_o  (low)
    );

    always_comb begin
        res_d     = res_q;
        res_d.low = low;
        res_d.top = top;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_o = res_q;

endmodule

// File: rtl/mm_tri_adder_chk.sv
module mm_tri_adder_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode_i,
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic [N:0]   res_o
);
    localparam logic [N+1:0] MOD_LO = {2'b00, {N{1'b1}}};
    localparam logic [N+1:0] MOD_HI = {2'b01, {(N-1){1'b0}}, 1'b1};
    localparam logic [N+1:0] ONE    = {{(N+1){1'b0}}, 1'b1};

    function automatic logic [N+1:0] model(input logic [1:0] md,
                                           input logic [N-1:0] a,
                                           input logic [N-1:0] b);
        logic [N+1:0] s;
        s = {2'b00, a} + {2'b00, b};
        case (md)
            2'b01:   model = s % MOD_LO;
            2'b10:   model = (s + ONE) % MOD_HI;
            default: model = {2'b00, s[N-1:0]};
        endcase
    endfunction

    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (res_o == '0);
        end
    end

    a_r2_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(mode_i) == 2'b00) |->
        ({1'b0, res_o} == model(2'b00, $past(a_i), $past(b_i))));

    a_r3_minus1: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(mode_i) == 2'b01) |->
        ({1'b0, res_o} == model(2'b01, $past(a_i), $past(b_i))));

    a_r4_no_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(mode_i) == 2'b01) |->
        (res_o != {1'b0, {N{1'b1}}}));

    a_r5_plus1: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(mode_i) == 2'b10) |->
        ({1'b0, res_o} == model(2'b10, $past(a_i), $past(b_i))));

    a_r5_top_alone: assert property (@(posedge clk) disable iff (!rst_n)
        res_o[N] |-> (res_o[N-1:0] == '0));

    a_r6_spare: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(mode_i) == 2'b11) |->
        ({1'b0, res_o} == model(2'b00, $past(a_i), $past(b_i))));

endmodule

bind mm_tri_adder mm_tri_adder_chk #(.N(N)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (res_o)
);

// File: tb/mm_tri_adder_tb_top.sv
`timescale 1ns/1ps
module mm_tri_adder_tb_top;
    import mm_pkg::*;

    localparam int CLK_NS = 8;

    typedef struct {
        logic [1:0]  md;
        logic [31:0] a;
        logic [31:0] b;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic [31:0] a32;
    logic [31:0] b32;
    logic [16:0] r_sk;
    logic [16:0] r_ks;
    logic [16:0] r_bk;
    logic [8:0]  r_w8;
    logic [32:0] r_w32;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    mm_tri_adder dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .a_i(a32[15:0]), .b_i(b32[15:0]), .res_o(r_sk));

    mm_tri_adder #(.N(16), .TOPO(TOPO_KOGGE)) dut_ks_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .a_i(a32[15:0]), .b_i(b32[15:0]), .res_o(r_ks));

    mm_tri_adder #(.N(16), .TOPO(TOPO_BRENT)) dut_bk_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .a_i(a32[15:0]), .b_i(b32[15:0]), .res_o(r_bk));

    mm_tri_adder #(.N(8), .TOPO(TOPO_BRENT)) dut_w8_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .a_i(a32[7:0]), .b_i(b32[7:0]), .res_o(r_w8));

    mm_tri_adder #(.N(32), .TOPO(TOPO_KOGGE)) dut_w32_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .a_i(a32), .b_i(b32), .res_o(r_w32));

    function automatic longint unsigned ref_sum(input int n, input logic [1:0] md,
                                                input logic [31:0] a, input logic [31:0] b);
        longint unsigned mask;
        longint unsigned x;
        longint unsigned y;
        mask = (64'd1 << n) - 64'd1;
        x = {32'd0, a} & mask;
        y = {32'd0, b} & mask;
        case (md)
            2'b01:   return (x + y) % mask;
            2'b10:   return (x + y + 64'd1) % (mask + 64'd2);
            default: return (x + y) & mask;
        endcase
    endfunction

    task automatic check(input string tag, input string inst,
                         input longint unsigned got, input longint unsigned exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, inst, got, exp);
        end
    endtask

    task automatic drive(input logic [1:0] md, input logic [31:0] a, input logic [31:0] b);
        item_t it;
        @(negedge clk);
        mode = md;
        a32  = a;
        b32  = b;
        it.md = md;
        it.a  = a;
        it.b  = b;
        sb_q.push_back(it);
    endtask

    // Monitor: one register between inputs and res_o, so the result of the
    // item pushed at a falling edge is visible just after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb_q.size() > 0) begin
                item_t it;
                string tag;
                it = sb_q.pop_front();
                case (it.md)
                    2'b00:   tag = "R2";
                    2'b01:   tag = "R3 R4";
                    2'b10:   tag = "R5";
                    default: tag = "R6";
                endcase
                check(tag,  "dut_i",     {47'd0, r_sk},  ref_sum(16, it.md, it.a, it.b));
                check("R7", "dut_ks_i",  {47'd0, r_ks},  ref_sum(16, it.md, it.a, it.b));
                check("R7", "dut_bk_i",  {47'd0, r_bk},  ref_sum(16, it.md, it.a, it.b));
                check("R8", "dut_w8_i",  {55'd0, r_w8},  ref_sum(8,  it.md, it.a, it.b));
                check("R8", "dut_w32_i", {31'd0, r_w32}, ref_sum(32, it.md, it.a, it.b));
            end
        end
    end

    initial begin
        #(CLK_NS * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] corner_a [6];
        logic [31:0] corner_b [6];
        rst_n = 1'b0;
        mode  = 2'b01;
        a32   = 32'hFFFF_FFFF;
        b32   = 32'h1234_5678;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset holds the output at zero whatever the inputs are
        check("R1", "dut_i",     {47'd0, r_sk},  64'd0);
        check("R1", "dut_w8_i",  {55'd0, r_w8},  64'd0);
        check("R1", "dut_w32_i", {31'd0, r_w32}, 64'd0);
        rst_n = 1'b1;
        #1;
        check("R1", "dut_i",    {47'd0, r_sk}, 64'd0);
        check("R1", "dut_bk_i", {47'd0, r_bk}, 64'd0);

        corner_a[0] = 32'hFFFF_FFFF; corner_b[0] = 32'hFFFF_FFFF;
        corner_a[1] = 32'hFFFF_FFFF; corner_b[1] = 32'h0000_0000;
        corner_a[2] = 32'h0000_0000; corner_b[2] = 32'h0000_0000;
        corner_a[3] = 32'h5555_5555; corner_b[3] = 32'hAAAA_AAAA;
        corner_a[4] = 32'hFFFF_FFFF; corner_b[4] = 32'h0000_0001;
        corner_a[5] = 32'h0000_0001; corner_b[5] = 32'hFFFF_FFFE;
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 6; k++) begin
                drive(m[1:0], corner_a[k], corner_b[k]);
            end
        end
        for (int n = 0; n < 800; n++) begin
            drive(n[1:0], $urandom, $urandom);
        end
        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule